// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a function return will jump. Each time a call is reported, it records the address of the instruction that follows the call. When a return is reported, the most recently recorded address comes out as the predicted target in the same cycle, and that entry is removed. Because calls nest, the stack returns targets in the reverse of the order in which the calls arrived.

Storage is a circular buffer with a top-of-stack pointer. When the stack is full and another call arrives, the write wraps around and overwrites the oldest entry instead of stalling the front end. Very deep call chains therefore lose their outermost return targets. An occupancy counter, capped at the depth, keeps the block from predicting out of an empty stack.

The fetch stage uses the block directly. It drives `push_i` together with the call address for a call, and `pop_i` for a return. It then takes `pred_target_o` as the next fetch address whenever `pred_valid_o` is high.

Top module: `ras_predictor`

## Requirements
- R1: A push stores the call address plus INST_BYTES (default 4). A later pop drives that value on pred_target_o with pred_valid_o high, combinationally in the cycle in which pop_i is high.
- R2: Entries pop in last-in first-out order: after pushes of calls A, B, C, three pops return C+4, B+4, A+4.
- R3: A pop with an empty stack drives pred_valid_o low and leaves the pointer and occupancy unchanged. A later push and pop still behave as on a fresh stack, and a further pop is again invalid.
- R4: The stack holds DEPTH (default 16) entries. After exactly DEPTH pushes, DEPTH pops are valid and in reverse order, and the next pop is invalid.
- R5: A push onto a full stack overwrites the oldest entry. After DEPTH+4 pushes, DEPTH pops return the newest DEPTH targets, newest first, and the following pop is invalid.
- R6: A push and a pop in the same cycle on a non-empty stack predict the old top entry and replace it with the new call address plus 4. Occupancy is unchanged, so the next pops return the new value and then the entry that lay below the old top.
- R7: A push and a pop in the same cycle on an empty stack drive pred_valid_o low and act as a plain push.
- R8: After reset the stack is empty: a pop drives pred_valid_o low.
- R9: pred_valid_o is low in every cycle in which pop_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | A call is reported this cycle |
| push_pc_i | input | ADDR_W | Address of the call instruction |
| pop_i | input | 1 | A return is reported this cycle |
| pred_target_o | output | ADDR_W | Predicted return target |
| pred_valid_o | output | 1 | The prediction is backed by a stored entry |

## Verification
A wrong pointer or occupancy value inside the block does not show at the ports right away. It shows on the next return, either as a target taken from the wrong slot or as a valid flag with the wrong value. An off-by-one in the wrap logic therefore shows only once a call chain deeper than the buffer unwinds, and that can be up to DEPTH pops after the fault. The stimulus includes full-depth and overflowing chains, combined push-and-pop cycles, and pops past the bottom of the stack, so that every such state is read back through the prediction outputs within a few cycles.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } ras_op_e;

  function automatic ras_op_e decode_op(input logic push, input logic pop);
    return ras_op_e'({push, pop});
  endfunction
endpackage

// File: rtl/ras_ret_addr.sv
module ras_ret_addr #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic [ADDR_W-1:0] call_pc_i,
  output logic [ADDR_W-1:0] ret_pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  generate
    if (INST_BYTES == 0) begin : g_same
      assign ret_pc_o = call_pc_i;
    end else begin : g_step
      assign ret_pc_o = call_pc_i + STEP;
    end
  endgenerate
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic             nonempty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] tos_q, tos_d;   // next free slot
  logic [CNT_W-1:0] occ_q, occ_d;
  logic [PTR_W-1:0] tos_inc, tos_dec;
  ras_op_e          op;

  assign tos_inc    = (tos_q == LAST) ? '0 : tos_q + 1'b1;
  assign tos_dec    = (tos_q == '0) ? LAST : tos_q - 1'b1;
  assign nonempty_o = (occ_q != '0);
  assign rd_idx_o   = tos_dec;
  assign op         = decode_op(push_i, pop_i);

  always_comb begin
    tos_d    = tos_q;
    occ_d    = occ_q;
    wr_en_o  = 1'b0;
    wr_idx_o = tos_q;
    unique case (op)
      OP_PUSH: begin
        wr_en_o = 1'b1;
        tos_d   = tos_inc;
        if (occ_q != FULL) occ_d = occ_q + 1'b1;
      end
      OP_POP: begin
        if (nonempty_o) begin
          tos_d = tos_dec;
          occ_d = occ_q - 1'b1;
        end
      end
      OP_SWAP: begin
        wr_en_o = 1'b1;
        if (nonempty_o) begin
          wr_idx_o = tos_dec;  // overwrite top in place
        end else begin
          tos_d = tos_inc;
          occ_d = occ_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= '0;
      occ_q <= '0;
    end else begin
      tos_q <= tos_d;
      occ_q <= occ_d;
    end
  end

  a_r4_occ_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= FULL);

  a_r3_empty_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && occ_q == '0) |=> (tos_q == $past(tos_q) && occ_q == '0));

  a_r6_swap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && push_i && occ_q != '0) |=> (tos_q == $past(tos_q) && occ_q == $past(occ_q)));

  a_r1_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && occ_q != FULL) |=> occ_q == $past(occ_q) + 1'b1);

  a_r5_full_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && occ_q == FULL) |=> occ_q == FULL);

  a_r2_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && occ_q != '0) |=> occ_q == $past(occ_q) - 1'b1);
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];

  a_r1_entry_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int DEPTH      = 16,
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_pc_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic              pred_valid_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic              nonempty;
  logic [ADDR_W-1:0] ret_pc;

  ras_ret_addr #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_ret (
    .call_pc_i (push_pc_i),
    .ret_pc_o  (ret_pc)
  );

  ras_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .rd_idx_o   (rd_idx),
    .nonempty_o (nonempty)
  );

  ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (ret_pc),
    .rd_idx_i  (rd_idx),
    .rd_data_o (pred_target_o)
  );

  assign pred_valid_o = pop_i & nonempty;

  a_r9_valid_needs_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> pop_i);

  a_r1_push_then_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) ##1 (pop_i && !push_i) |-> (pred_valid_o && pred_target_o == $past(ret_pc)));
endmodule

// File: tb/ras_predictor_tb.sv
module ras_predictor_tb_top;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              push_i = 1'b0;
  logic [ADDR_W-1:0] push_pc_i = '0;
  logic              pop_i = 1'b0;
  logic [ADDR_W-1:0] pred_target_o;
  logic              pred_valid_o;

  int checks = 0;
  int errors = 0;

  logic [ADDR_W-1:0] model[$];
  logic              exp_v[$];
  logic [ADDR_W-1:0] exp_t[$];
  string             exp_r[$];

  always #4 clk = ~clk;

  ras_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INST_BYTES(4)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .push_i (push_i), .push_pc_i (push_pc_i),
    .pop_i (pop_i), .pred_target_o (pred_target_o), .pred_valid_o (pred_valid_o)
  );

  task automatic step(input logic p, input logic [ADDR_W-1:0] pc, input logic q, input string req);
    @(negedge clk);
    push_i = p; push_pc_i = pc; pop_i = q;
    if (q) begin
      if (model.size() == 0) begin
        exp_v.push_back(1'b0); exp_t.push_back('0);
        if (p) model.push_back(pc + 4);
      end else begin
        exp_v.push_back(1'b1); exp_t.push_back(model[$]);
        if (p) model[model.size()-1] = pc + 4;
        else void'(model.pop_back());
      end
      exp_r.push_back(req);
    end else if (p) begin
      if (model.size() == DEPTH) void'(model.pop_front());
      model.push_back(pc + 4);
    end
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, "R9");
  endtask

  // monitor: compares outputs against queued expectations
  always @(negedge clk) begin
    #3;
    if (rst_ni) begin
      if (pop_i) begin
        if (exp_v.size() == 0) begin
          errors++; checks++;
          $display("FAIL monitor: pop with no expectation queued (actual valid=%0b expected none)", pred_valid_o);
        end else begin
          logic ev; logic [ADDR_W-1:0] et; string er;
          ev = exp_v.pop_front(); et = exp_t.pop_front(); er = exp_r.pop_front();
          checks++;
          if (pred_valid_o !== ev || (ev && pred_target_o !== et)) begin
            errors++;
            $display("FAIL %s: actual valid=%0b target=%h expected valid=%0b target=%h",
                     er, pred_valid_o, pred_target_o, ev, et);
          end
        end
      end else begin
        checks++;
        if (pred_valid_o !== 1'b0) begin
          errors++;
          $display("FAIL R9: actual valid=%0b expected 0 without pop", pred_valid_o);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual run still going, expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R8: reset leaves stack empty
    step(1'b0, '0, 1'b1, "R8");
    idle();
    // R1 / R2: nested calls unwind in reverse
    step(1'b1, 32'h0000_1000, 1'b0, "R1");
    step(1'b0, '0, 1'b1, "R1");
    step(1'b1, 32'h0000_2000, 1'b0, "R2");
    step(1'b1, 32'h0000_3000, 1'b0, "R2");
    step(1'b1, 32'h0000_4000, 1'b0, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, "R2");
    // R3: empty pop, pointer held
    step(1'b1, 32'h0000_5000, 1'b0, "R3");
    step(1'b1, 32'h0000_6000, 1'b0, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, "R3");
    step(1'b1, 32'h0000_7000, 1'b0, "R3");
    step(1'b0, '0, 1'b1, "R3");
    step(1'b0, '0, 1'b1, "R3");
    idle();
    // R4: exactly full
    for (int i = 0; i < DEPTH; i++) step(1'b1, 32'h0001_0000 + 32'(i * 16), 1'b0, "R4");
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, '0, 1'b1, "R4");
    // R5: overflow drops oldest
    for (int i = 0; i < DEPTH + 4; i++) step(1'b1, 32'h0002_0000 + 32'(i * 32), 1'b0, "R5");
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, '0, 1'b1, "R5");
    // R6: combined push+pop on non-empty stack
    step(1'b1, 32'h0003_0000, 1'b0, "R6");
    step(1'b1, 32'h0003_0100, 1'b0, "R6");
    step(1'b1, 32'h0003_0200, 1'b1, "R6");
    step(1'b1, 32'h0003_0300, 1'b1, "R6");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, "R6");
    // R7: combined push+pop on empty stack
    step(1'b1, 32'h0004_0000, 1'b1, "R7");
    step(1'b0, '0, 1'b1, "R7");
    step(1'b0, '0, 1'b1, "R7");
    // R6 after overflow: swap on full stack keeps depth
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 32'h0005_0000 + 32'(i * 8), 1'b0, "R6");
    step(1'b1, 32'h0006_0000, 1'b1, "R6");
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, '0, 1'b1, "R6");
    idle();
    idle();
    @(negedge clk);
    #5;
    if (exp_v.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual %0d expectations left, expected 0", exp_v.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule